// File: doc/BRIEF.md
# Write-Once Programmable Tick Divider

This block turns a fast oscillator clock into a slow, evenly spaced timing enable for a nonvolatile memory controller. Software configures it through one 8-bit register. The register holds a prescaler select, a 6-bit divide field and a read-only flag that shows whether the configuration has been loaded.

The configuration can be written only once after reset. The first write to the register takes effect and sets the loaded flag. Every later write is dropped until the next reset. When the prescaler is selected, the oscillator first passes through a fixed divide-by-8 stage. The programmable stage then divides by the field value plus one, so the largest overall ratio is 512. The output is a one-cycle enable pulse in the oscillator domain, not a generated clock. It stays low until the configuration is loaded.

Two reserved neighbouring addresses, and the one unused address in the small address space, read as zero and ignore writes. The register port is a plain write strobe with a combinational read. There is no data stream, so no valid/ready handshake is used.

Top module: `nvm_tick_div`

## Requirements
- R1: Bit 7 of address 0 reads 0 from reset until the first write to address 0. From that write on it reads 1, until the next reset.
- R2: Bit 7 of the write data has no effect. The value read back in bit 7 is always the loaded flag.
- R3: The first write to address 0 after reset loads write-data bits 6..0 into the register. Every later write to address 0 leaves bits 6..0 and the tick timing unchanged until reset.
- R4: After reset, address 0 reads 0x00 and `tick` is low.
- R5: With bit 6 = 0 and divide field N (bits 5..0), `tick` is high in cycle N and then every N+1 cycles. Cycle 0 is the cycle right after the accepted write edge. With N = 0, `tick` is high in every cycle.
- R6: With bit 6 = 1 and field N, `tick` is high in cycle 8(N+1)-1 and then every 8(N+1) cycles. The maximum ratio is 512.
- R7: `tick` stays low while the loaded flag is 0.
- R8: Addresses 1, 2 and 3 always read 0x00. Writes to them change nothing, and they do not set the loaded flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0 = config, 1..3 reserved) |
| reg_we | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tick | output | 1 | One-cycle timing enable |

## Verification
The assertions assume that `reg_addr`, `reg_we` and `reg_wdata` are known and synchronous to `clk`, and that each write is a single-cycle strobe. Under those conditions the tick spacing always matches the locked configuration. The bench drives every bus input at the falling edge and holds `reg_we` high for exactly one rising edge. It issues repeat writes and reserved-address writes only inside those rules. Because the configuration locks, the bench applies a fresh reset before each new divide setting.

// File: rtl/nvm_tick_div_pkg.sv
package nvm_tick_div_pkg;
  localparam int ADDR_W     = 2;
  localparam int PRE_LOG2   = 3;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
endpackage

// File: rtl/ntd_cfg_reg.sv
module ntd_cfg_reg #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg,
  input  logic             wr_prediv,
  input  logic [DIV_W-1:0] wr_div,
  output logic             loaded,
  output logic             prediv,
  output logic [DIV_W-1:0] div,
  output logic             accept
);
  // only the first write after reset is taken
  assign accept = wr_cfg && !loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      prediv <= 1'b0;
      div    <= '0;
    end else if (accept) begin
      loaded <= 1'b1;
      prediv <= wr_prediv;
      div    <= wr_div;
    end
  end
endmodule

// File: rtl/ntd_prescaler.sv
module ntd_prescaler #(
  parameter int PRE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic enable_div,
  output logic step
);
  logic [PRE_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // bypass gives one step per cycle; otherwise one per 2**PRE_LOG2 cycles
  assign step = run && (!enable_div || (&cnt));
endmodule

// File: rtl/ntd_tick_counter.sv
module ntd_tick_counter #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_limit;

  assign at_limit = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (step)    cnt <= at_limit ? '0 : cnt + 1'b1;
  end

  assign tick = step && at_limit;
endmodule

// File: rtl/nvm_tick_div.sv
module nvm_tick_div
  import nvm_tick_div_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DIV_W+1:0]  reg_wdata,
  output logic [DIV_W+1:0]  reg_rdata,
  output logic              tick
);
  localparam int REG_W = DIV_W + 2;

  logic             loaded;
  logic             cfg_prediv;
  logic [DIV_W-1:0] cfg_div;
  logic             accept;
  logic             step;
  logic             cfg_sel;

  assign cfg_sel = (reg_addr == ADDR_CFG);

  ntd_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cfg    (reg_we && cfg_sel),
    .wr_prediv (reg_wdata[DIV_W]),
    .wr_div    (reg_wdata[DIV_W-1:0]),
    .loaded    (loaded),
    .prediv    (cfg_prediv),
    .div       (cfg_div),
    .accept    (accept)
  );

  ntd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (loaded),
    .clear      (accept),
    .enable_div (cfg_prediv),
    .step       (step)
  );

  ntd_tick_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (step),
    .limit (cfg_div),
    .tick  (tick)
  );

  // reserved and unused addresses read zero
  always_comb begin
    reg_rdata = '0;
    if (cfg_sel) reg_rdata = {loaded, cfg_prediv, cfg_div};
  end

  logic unused_ok;
  assign unused_ok = (REG_W == $bits(reg_rdata));
endmodule

// File: rtl/nvm_tick_div_chk.sv
module nvm_tick_div_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_we,
  input logic [DIV_W+1:0] reg_wdata,
  input logic [DIV_W+1:0] reg_rdata,
  input logic             tick,
  input logic             loaded,
  input logic             cfg_prediv,
  input logic [DIV_W-1:0] cfg_div
);
  localparam int CW = DIV_W + 5;

  logic [CW-1:0] gap;
  logic          seen;
  logic [CW-1:0] ratio;

  assign ratio = ({{(CW-DIV_W){1'b0}}, cfg_div} + 1'b1) << (cfg_prediv ? 3 : 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (!(&gap)) begin
      gap  <= gap + 1'b1;
    end
  end

  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded); // R1
  AST_FLAG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[DIV_W+1] == loaded)); // R2
  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded && reg_we && reg_addr == 2'd0) |=>
      (loaded && cfg_div == $past(reg_wdata[DIV_W-1:0]) && cfg_prediv == $past(reg_wdata[DIV_W]))); // R3
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> ($stable(cfg_div) && $stable(cfg_prediv))); // R3
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (gap == ratio - 1'b1)); // R5
  AST_TICK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_prediv) |=> !tick); // R6
  AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tick); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 2'd0) |-> (reg_rdata == '0)); // R8
  AST_RSVD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded && reg_we && reg_addr != 2'd0) |=> !loaded); // R8
endmodule

bind nvm_tick_div nvm_tick_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .tick       (tick),
  .loaded     (loaded),
  .cfg_prediv (cfg_prediv),
  .cfg_div    (cfg_div)
);

// File: tb/tb_nvm_tick_div.sv
`timescale 1ns/1ps
module tb_nvm_tick_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    win_end = 0;
  int    exp_q[$];
  string cur_tag = "R5";

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_tick_div dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: compares ticks with the queue of expected cycles
  always @(negedge clk) begin
    if (rst_n && cyc < win_end) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        chk(1'b0, {cur_tag, " missed tick"}, 0, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (tick) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          chk(1'b1, cur_tag, cyc, cyc);
          void'(exp_q.pop_front());
        end else begin
          chk(1'b0, {cur_tag, " unexpected tick"}, cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_we = 1'b0; win_end = 0; exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic check_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  // driver: pushes expected tick cycles, then issues the configuring write
  task automatic start_cfg(input logic [7:0] d, input int len, input string tag);
    int per;
    int base;
    @(negedge clk);
    per  = (int'(d[5:0]) + 1) * (d[6] ? 8 : 1);
    base = cyc + 1;
    cur_tag = tag;
    for (int t = base + per - 1; t < base + len; t += per) exp_q.push_back(t);
    win_end = base + len;
    reg_addr = 2'd0; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_win(input string tag);
    while (cyc < win_end) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " pending ticks"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R4: reset state
    check_read(2'd0, 8'h00, "R4 reset readback");
    chk(tick == 1'b0, "R4 tick after reset", tick, 0);

    // R8 / R7: reserved writes do nothing, no ticks while unloaded
    cur_tag = "R7";
    win_end = cyc + 40;
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    check_read(2'd1, 8'h00, "R8 reserved 1");
    check_read(2'd2, 8'h00, "R8 reserved 2");
    check_read(2'd3, 8'h00, "R8 unused 3");
    check_read(2'd0, 8'h00, "R8 R1 no lock from reserved");
    wait_win("R7");

    // R5: N=5 without prescaler, then flag set (R1)
    start_cfg(8'h05, 40, "R5 N=5");
    check_read(2'd0, 8'h85, "R1 loaded flag");
    wait_win("R5 N=5");

    // R2: bit 7 of write data does not write; ratio 1 ticks every cycle
    do_reset();
    start_cfg(8'h80, 20, "R2 R5 N=0");
    check_read(2'd0, 8'h80, "R2 flag only");
    wait_win("R2 R5 N=0");

    // R3: later write ignored
    do_reset();
    start_cfg(8'h02, 60, "R3 locked");
    repeat (10) @(negedge clk);
    bus_write(2'd0, 8'h47);
    check_read(2'd0, 8'h82, "R3 second write ignored");
    wait_win("R3 locked");

    // R5: largest field without prescaler
    do_reset();
    start_cfg(8'h3F, 200, "R5 N=63");
    wait_win("R5 N=63");

    // R6: prescaler on
    do_reset();
    start_cfg(8'h43, 120, "R6 N=3");
    check_read(2'd0, 8'hC3, "R6 readback");
    wait_win("R6 N=3");

    // R6: maximum ratio 512
    do_reset();
    start_cfg(8'h7F, 1100, "R6 max");
    wait_win("R6 max");

    // R4: reset clears lock
    do_reset();
    check_read(2'd0, 8'h00, "R4 R1 cleared by reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule